// File: doc/BRIEF.md
# Complementary Gate Output Shaper

This block takes a single raw pulse-width-modulated bit and turns it into two drive signals for the upper and lower power switches of one inverter leg. A high raw bit asks for the upper switch, a low raw bit asks for the lower switch. On the way, level changes that do not last long enough are discarded, and every hand-over from one switch to the other passes through a programmable interval in which both drives are low. A programmed count of 0 disables either function.

A protective shutdown path sits above all of this. A hardware trip input, synchronised into the clock domain, forces both drives low within two to three clock periods and latches. A software trip pulse does the same. The latched state is released only by a software clear pulse, and only once the synchronised hardware trip has gone low. A status output shows whether the drives are currently held off.

Top module: `gos_gate_shaper`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `drv_top`, `drv_bot` and `tripped` are all low.
- R2: `drv_top` and `drv_bot` are never high in the same cycle.
- R3: With `underlap` = N > 0, a hand-over from one switch to the other leaves exactly N cycles with both drives low between the falling edge of one drive and the rising edge of the other.
- R4: With `min_width` = M > 1, a raw level that differs from the accepted level for fewer than M consecutive sampled cycles never reaches the drives; one that lasts M cycles is accepted on the Mth cycle. The raw bit is registered once before filtering.
- R5: A deleted pulse leaves the drives exactly as they were: no drive falls and no both-low interval is produced.
- R6: When `trip_in` rises and stays high, `tripped` goes high and both drives go low on the second rising clock edge that samples it high, and stay so after `trip_in` falls.
- R7: A one-cycle `sw_trip` pulse sets `tripped` and forces both drives low from the next clock edge on.
- R8: A `sw_clear` pulse releases the trip only when the synchronised `trip_in` is low; released, the leg restarts from both-low and turns on the requested switch after the underlap count.
- R9: Whenever `tripped` is high, `drv_top` and `drv_bot` are low.
- R10: With `underlap` = 0 a hand-over swaps the drives in one clock edge with no both-low cycle; with `min_width` of 0 or 1 every raw change is accepted one cycle after it is registered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | Raw modulated bit, 1 requests the upper switch |
| min_width | input | CW (8) | Minimum accepted pulse length in clocks, 0 disables |
| underlap | input | CW (8) | Both-off interval in clocks at each hand-over, 0 disables |
| trip_in | input | 1 | Asynchronous hardware trip request, active high |
| sw_trip | input | 1 | One-cycle software trip pulse |
| sw_clear | input | 1 | One-cycle software trip release pulse |
| drv_top | output | 1 | Upper switch drive |
| drv_bot | output | 1 | Lower switch drive |
| tripped | output | 1 | High while the drives are held off by a trip |

## Verification
The assertions watch, every cycle, that the two drives never overlap, that a switch is entered only from the both-low state whenever the underlap is non-zero, that the accepted level only ever moves toward the registered raw value, and that the trip path meets its two-edge latency, its software set and its blocked clear. The exact lengths of both-low gaps, which pulses are deleted against the programmed minimum, that a deleted pulse leaves no gap behind, and the restart sequence after a clear depend on the history of the stimulus, so only the bench's reference model, compared cycle by cycle under directed and random patterns, can show them.

// File: rtl/gos_pkg.sv
package gos_pkg;

    // Which switch of the leg is being driven.
    typedef enum logic [1:0] {
        LEG_OFF = 2'd0,
        LEG_TOP = 2'd1,
        LEG_BOT = 2'd2
    } leg_state_e;

    typedef struct packed {
        logic top;
        logic bot;
    } gate_t;

    function automatic gate_t gate_of(leg_state_e s);
        gate_t g;
        g.top = (s == LEG_TOP);
        g.bot = (s == LEG_BOT);
        return g;
    endfunction

    function automatic leg_state_e side_of(logic want_top);
        return want_top ? LEG_TOP : LEG_BOT;
    endfunction

endpackage

// File: rtl/gos_pulse_filter.sv
module gos_pulse_filter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          raw_i,
    input  logic [CW-1:0] min_width_i,
    output logic          level_o
);
    localparam int EW = CW + 1;

    logic          raw_q;
    logic          level_q;
    logic [CW-1:0] run_q;
    logic [EW-1:0] run_next;

    assign run_next = {1'b0, run_q} + EW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q   <= 1'b0;
            level_q <= 1'b0;
            run_q   <= '0;
        end else begin
            raw_q <= raw_i;
            if (raw_q != level_q) begin
                if (run_next >= {1'b0, min_width_i}) begin
                    level_q <= raw_q;
                    run_q   <= '0;
                end else begin
                    run_q <= run_next[CW-1:0];
                end
            end else begin
                run_q <= '0;
            end
        end
    end

    assign level_o = level_q;

    AST_FILT_TOWARD_RAW: assert property (@(posedge clk) disable iff (rst)
        (level_q != $past(level_q)) |-> (level_q == $past(raw_q))); // R4

endmodule

// File: rtl/gos_deadtime.sv
module gos_deadtime
    import gos_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          level_i,
    input  logic          kill_i,
    input  logic [CW-1:0] underlap_i,
    output gate_t         gate_o
);
    leg_state_e    state_q, state_d;
    logic [CW-1:0] gap_q, gap_d;
    leg_state_e    want;

    assign want = side_of(level_i);

    always_comb begin
        state_d = state_q;
        gap_d   = gap_q;
        if (kill_i) begin
            state_d = LEG_OFF;
            gap_d   = '0;
        end else if (state_q == want) begin
            gap_d = '0;
        end else if (state_q != LEG_OFF) begin
            if (underlap_i == '0) begin
                state_d = want;
                gap_d   = '0;
            end else begin
                state_d = LEG_OFF;
                gap_d   = CW'(1);
            end
        end else if (gap_q >= underlap_i) begin
            state_d = want;
            gap_d   = '0;
        end else begin
            gap_d = gap_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LEG_OFF;
            gap_q   <= '0;
        end else begin
            state_q <= state_d;
            gap_q   <= gap_d;
        end
    end

    assign gate_o = gate_of(state_q);

    AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (rst)
        !(gate_o.top && gate_o.bot)); // R2

    AST_TOP_FROM_OFF: assert property (@(posedge clk) disable iff (rst)
        (underlap_i != '0 && $stable(underlap_i) && gate_o.top && !$past(gate_o.top))
        |-> !$past(gate_o.bot)); // R3

    AST_BOT_FROM_OFF: assert property (@(posedge clk) disable iff (rst)
        (underlap_i != '0 && $stable(underlap_i) && gate_o.bot && !$past(gate_o.bot))
        |-> !$past(gate_o.top)); // R3

endmodule

// File: rtl/gos_trip_ctrl.sv
module gos_trip_ctrl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic trip_i,
    input  logic set_i,
    input  logic clear_i,
    output logic tripped_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   hw_trip;
    logic                   latch_q;
    logic [1:0]             age_q;

    assign hw_trip = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= '0;
            latch_q <= 1'b0;
            age_q   <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], trip_i};
            if (hw_trip || set_i) begin
                latch_q <= 1'b1;
            end else if (clear_i) begin
                latch_q <= 1'b0;
            end
            if (age_q != 2'd3) begin
                age_q <= age_q + 2'd1;
            end
        end
    end

    // Synchronised request gates the drives at once; the latch holds it.
    assign tripped_o = latch_q | hw_trip;

    AST_TRIP_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 2'd2 && $past(trip_i, 2)) |-> tripped_o); // R6

    AST_SW_TRIP_SETS: assert property (@(posedge clk) disable iff (rst)
        set_i |=> tripped_o); // R7

    AST_CLEAR_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (hw_trip && clear_i) |=> tripped_o); // R8

endmodule

// File: rtl/gos_gate_shaper.sv
module gos_gate_shaper
    import gos_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pwm_in,
    input  logic [CW-1:0] min_width,
    input  logic [CW-1:0] underlap,
    input  logic          trip_in,
    input  logic          sw_trip,
    input  logic          sw_clear,
    output logic          drv_top,
    output logic          drv_bot,
    output logic          tripped
);
    logic  level;
    logic  trip_now;
    gate_t gate;

    gos_pulse_filter #(.CW(CW)) u_filter (
        .clk         (clk),
        .rst         (rst),
        .raw_i       (pwm_in),
        .min_width_i (min_width),
        .level_o     (level)
    );

    gos_trip_ctrl #(.SYNC_STAGES(2)) u_trip (
        .clk       (clk),
        .rst       (rst),
        .trip_i    (trip_in),
        .set_i     (sw_trip),
        .clear_i   (sw_clear),
        .tripped_o (trip_now)
    );

    gos_deadtime #(.CW(CW)) u_dead (
        .clk        (clk),
        .rst        (rst),
        .level_i    (level),
        .kill_i     (trip_now),
        .underlap_i (underlap),
        .gate_o     (gate)
    );

    assign drv_top = gate.top & ~trip_now;
    assign drv_bot = gate.bot & ~trip_now;
    assign tripped = trip_now;

    AST_OUT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(drv_top && drv_bot)); // R2

    AST_TRIP_HOLDS_OFF: assert property (@(posedge clk) disable iff (rst)
        $past(tripped) |-> (gate.top == 1'b0 && gate.bot == 1'b0)); // R9

endmodule

// File: tb/gos_gate_shaper_bench.sv
module gos_gate_shaper_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwm_in = 1'b0;
    logic [7:0] min_width = 8'd0;
    logic [7:0] underlap = 8'd0;
    logic       trip_in = 1'b0;
    logic       sw_trip = 1'b0;
    logic       sw_clear = 1'b0;
    logic       drv_top, drv_bot, tripped;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    gos_gate_shaper #(.CW(8)) u_gos_gate_shaper (
        .clk(clk), .rst(rst), .pwm_in(pwm_in), .min_width(min_width),
        .underlap(underlap), .trip_in(trip_in), .sw_trip(sw_trip),
        .sw_clear(sw_clear), .drv_top(drv_top), .drv_bot(drv_bot),
        .tripped(tripped)
    );

    // Behavioural reference: leg state 0 = both off, 1 = upper, 2 = lower.
    int m_pq, m_acc, m_run, m_leg, m_gap, m_s1, m_s2, m_lat;

    always @(posedge clk) begin
        int kill, want, n_acc, n_run, n_leg, n_gap, n_lat;
        if (rst) begin
            m_pq = 0; m_acc = 0; m_run = 0; m_leg = 0; m_gap = 0;
            m_s1 = 0; m_s2 = 0; m_lat = 0;
        end else begin
            kill = m_lat | m_s2;
            n_acc = m_acc; n_run = 0;
            if (m_pq != m_acc) begin
                if (m_run + 1 >= int'(min_width)) n_acc = m_pq;
                else n_run = m_run + 1;
            end
            want = m_acc ? 1 : 2;
            n_leg = m_leg; n_gap = 0;
            if (kill != 0) n_leg = 0;
            else if (m_leg == want) n_leg = m_leg;
            else if (m_leg != 0) begin
                if (underlap == 0) n_leg = want;
                else begin n_leg = 0; n_gap = 1; end
            end else if (m_gap >= int'(underlap)) n_leg = want;
            else n_gap = m_gap + 1;
            n_lat = (m_s2 != 0 || sw_trip) ? 1 : (sw_clear ? 0 : m_lat);
            m_s2 = m_s1; m_s1 = int'(trip_in);
            m_lat = n_lat; m_acc = n_acc; m_run = n_run;
            m_leg = n_leg; m_gap = n_gap; m_pq = int'(pwm_in);
        end
    end

    task automatic step(input string tag);
        int e_trip, e_top, e_bot;
        @(negedge clk);
        e_trip = m_lat | m_s2;
        e_top  = (m_leg == 1 && e_trip == 0) ? 1 : 0;
        e_bot  = (m_leg == 2 && e_trip == 0) ? 1 : 0;
        checks++;
        if (int'(drv_top) != e_top || int'(drv_bot) != e_bot || int'(tripped) != e_trip) begin
            errors++;
            $display("FAIL %s t=%0t top/bot/trip actual %0b%0b%0b expected %0d%0d%0d",
                     tag, $time, drv_top, drv_bot, tripped, e_top, e_bot, e_trip);
        end
        checks++;
        if (drv_top && drv_bot) begin
            errors++;
            $display("FAIL R2 overlap actual 11 expected not both high");
        end
    endtask

    task automatic hold(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    task automatic pulse(input string tag, input logic lvl, input int len, input int rest);
        pwm_in = lvl;
        hold(tag, len);
        pwm_in = ~lvl;
        hold(tag, rest);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        hold("R1", 3);
        rst = 1'b0;
        hold("R1", 1);

        // R10: both functions disabled, immediate swaps
        min_width = 0; underlap = 0;
        for (int k = 0; k < 6; k++) pulse("R10", 1'b1, 5, 5);
        min_width = 1;
        for (int k = 0; k < 4; k++) pulse("R10", 1'b1, 1, 3);

        // R3: dead-time gaps, including toggles faster than the gap
        min_width = 0; underlap = 3;
        for (int k = 0; k < 4; k++) pulse("R3", 1'b1, 12, 12);
        for (int k = 0; k < 6; k++) pulse("R3", 1'b1, 2, 2);
        hold("R3", 10);

        // R4 / R5: short pulses deleted, long ones kept
        min_width = 4; underlap = 2;
        pwm_in = 1'b0; hold("R5", 15);
        pulse("R5", 1'b1, 2, 15);
        pulse("R5", 1'b1, 3, 15);
        pulse("R4", 1'b1, 4, 15);
        pulse("R4", 1'b1, 6, 15);
        pwm_in = 1'b1; hold("R4", 15);
        pulse("R5", 1'b0, 3, 15);
        pulse("R4", 1'b0, 5, 15);

        // R6 / R8 / R9: hardware trip, blocked clear, release
        trip_in = 1'b1; hold("R6", 6);
        sw_clear = 1'b1; step("R8");
        sw_clear = 1'b0; hold("R8", 3);
        trip_in = 1'b0; hold("R9", 6);
        sw_clear = 1'b1; step("R8");
        sw_clear = 1'b0; hold("R8", 12);

        // R7: software trip
        sw_trip = 1'b1; step("R7");
        sw_trip = 1'b0; hold("R7", 6);
        sw_clear = 1'b1; step("R8");
        sw_clear = 1'b0; hold("R8", 10);

        // Random mix with changing settings and occasional trips
        for (int blk = 0; blk < 8; blk++) begin
            min_width = 8'($urandom_range(0, 5));
            underlap  = 8'($urandom_range(0, 5));
            for (int c = 0; c < 300; c++) begin
                if ($urandom_range(0, 3) == 0) pwm_in = ~pwm_in;
                sw_trip  = ($urandom_range(0, 199) == 0);
                sw_clear = ($urandom_range(0, 19) == 0);
                trip_in  = (c >= 150 && c < 160);
                step("R2");
            end
            sw_trip = 1'b0; trip_in = 1'b0;
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule